// File: doc/BRIEF.md
# Inbound Mailbox Queue

This block is a small message queue that a coprocessor fills and a host processor drains over a simple 32-bit register bus. A channel router adds 32-bit words through a push port. The host reads them back one at a time through a pop window. The host can also look at the head word without removing it, read full and empty flags from a status word, and enable one interrupt that is raised while words are waiting. The status word of the opposite-direction mailbox is brought in on a port and can be read through the same bus.

Only the low 8 bits of the offset are decoded, and every access is a full 32-bit word. A pop from an empty queue does not stall. It returns the invalid-data marker 0xFFFFFFFF and leaves the queue unchanged. Storage is a shift queue with 8 entries by default. A pop moves every word one slot toward the head and refills the freed tail slot with the marker.

Top module: `inbox_mailbox`

## Requirements
- R1: Only bits [7:0] of `bus_addr` select a register; the upper address bits have no effect.
- R2: A read at any offset from 0x80 to 0x8C returns the head word and removes it. Words come out in the order they were pushed.
- R3: A pop read from an empty queue returns 0xFFFFFFFF and leaves the count and the contents unchanged.
- R4: A read at 0x90 returns the head slot and does not remove it. On an empty queue it returns 0xFFFFFFFF.
- R5: A read at 0x98 returns the status word. Bit 31 is 1 when the queue holds DEPTH words, bit 30 is 1 when it holds none, and all other bits are 0.
- R6: A write at 0x9C changes only config bit 0, the data interrupt enable. A read at 0x9C returns the enable in bit 0, a data-pending bit in bit 4 that is 1 whenever the queue is not empty, and 0 in all other bits.
- R7: `irq` is 1 exactly when the queue is not empty and the enable is 1. It takes its new value in the cycle after the push, pop or write that causes the change.
- R8: After reset the queue is empty, the config is 0, `irq` is 0, and every slot holds 0xFFFFFFFF.
- R9: A push while the queue already holds DEPTH words is dropped. This holds even if a pop happens in the same cycle.
- R10: Offset 0x94 reads 0 and ignores writes. Offset 0xB8 returns `obx_status`. Every other offset reads 0, and a write there changes nothing.
- R11: When a push and a pop happen in the same cycle, the pop returns the old head and the pushed word joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset; only the low 8 bits are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| push_valid | input | 1 | Router push strobe |
| push_data | input | 32 | Word to append |
| obx_status | input | 32 | Status word of the outbound mailbox |
| irq | output | 1 | Data-waiting interrupt |

## Verification
The bench fills the queue to its limit and goes on pushing. A design that accepted the extra word would corrupt the order or report a count past full. It drains the queue past empty. A design that stalled, or that moved the count on an empty pop, would give back something other than the marker or would lose later words. It repeats the peek with a pop in between, so a peek that removed the word or returned the wrong slot is caught. It also pushes and pops in the same cycle at empty, mid-level and full, so a design that got the order of the tail write and the shift wrong returns stale data. It writes all ones to config and to the unused offsets, and uses aliased upper address bits, to expose decoding of stray bits.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned WORD_W = 32;
    localparam logic [WORD_W-1:0] NO_DATA = 32'hFFFF_FFFF;

    localparam logic [7:0] OFS_POP_LO  = 8'h80;
    localparam logic [7:0] OFS_POP_HI  = 8'h8C;
    localparam logic [7:0] OFS_PEEK    = 8'h90;
    localparam logic [7:0] OFS_SENDER  = 8'h94;
    localparam logic [7:0] OFS_STATUS  = 8'h98;
    localparam logic [7:0] OFS_CONFIG  = 8'h9C;
    localparam logic [7:0] OFS_OBX     = 8'hB8;

    localparam int unsigned ST_FULL_BIT  = 31;
    localparam int unsigned ST_EMPTY_BIT = 30;
    localparam int unsigned CF_EN_BIT    = 0;
    localparam int unsigned CF_PEND_BIT  = 4;

    typedef enum logic [2:0] {
        RSEL_ZERO,
        RSEL_POP,
        RSEL_PEEK,
        RSEL_STATUS,
        RSEL_CONFIG,
        RSEL_OBX
    } rsel_e;

    typedef struct packed {
        logic  pop;
        logic  cfg_wr;
        rsel_e rsel;
    } dec_t;

    typedef struct packed {
        logic full;
        logic empty;
    } qflags_t;

    function automatic logic [WORD_W-1:0] status_word(qflags_t f);
        logic [WORD_W-1:0] w;
        w = '0;
        w[ST_FULL_BIT]  = f.full;
        w[ST_EMPTY_BIT] = f.empty;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] config_word(logic en, logic pend);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CF_EN_BIT]   = en;
        w[CF_PEND_BIT] = pend;
        return w;
    endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [7:0] ofs;

    assign ofs = addr[7:0];

    always_comb begin
        dec = '{pop: 1'b0, cfg_wr: 1'b0, rsel: RSEL_ZERO};
        if (sel && !wr) begin
            if (ofs >= OFS_POP_LO && ofs <= OFS_POP_HI) begin
                dec.rsel = RSEL_POP;
                dec.pop  = 1'b1;
            end else begin
                case (ofs)
                    OFS_PEEK:   dec.rsel = RSEL_PEEK;
                    OFS_STATUS: dec.rsel = RSEL_STATUS;
                    OFS_CONFIG: dec.rsel = RSEL_CONFIG;
                    OFS_OBX:    dec.rsel = RSEL_OBX;
                    default:    dec.rsel = RSEL_ZERO;
                endcase
            end
        end else if (sel && wr && ofs == OFS_CONFIG) begin
            dec.cfg_wr = 1'b1;
        end
    end
endmodule

// File: rtl/mbx_queue.sv
module mbx_queue
    import mbx_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop_req,
    input  logic              push_valid,
    input  logic [WORD_W-1:0] push_data,
    output logic [WORD_W-1:0] head,
    output qflags_t           flags
);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WORD_W-1:0] slot [DEPTH];
    logic [CW-1:0]     count;
    logic              do_pop;
    logic              do_push;
    logic [CW-1:0]     wr_idx;

    assign do_pop  = pop_req && (count != '0);
    assign do_push = push_valid && (count != FULL_CNT);
    assign wr_idx  = do_pop ? count - 1'b1 : count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) slot[i] <= NO_DATA;
        end else begin
            if (do_pop) begin
                for (int i = 0; i < DEPTH - 1; i++) slot[i] <= slot[i+1];
                slot[DEPTH-1] <= NO_DATA;
            end
            if (do_push) begin
                for (int i = 0; i < DEPTH; i++)
                    if (wr_idx == CW'(i)) slot[i] <= push_data;
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head        = slot[0];
    assign flags.full  = (count == FULL_CNT);
    assign flags.empty = (count == '0);

    AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (rst)
        (count == FULL_CNT) && push_valid && !pop_req |=> count == FULL_CNT); // R9
    AST_EMPTY_POP_STILL: assert property (@(posedge clk) disable iff (rst)
        (count == '0) && pop_req && !push_valid |=> count == '0); // R3
    AST_POP_SHRINK: assert property (@(posedge clk) disable iff (rst)
        (count != '0) && pop_req && !push_valid |=> count == $past(count) - 1'b1); // R2
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT); // R9
endmodule

// File: rtl/mbx_config.sv
module mbx_config
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic              irq_en
);
    always_ff @(posedge clk) begin
        if (rst) irq_en <= 1'b0;
        else if (cfg_wr) irq_en <= wdata[CF_EN_BIT];
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(irq_en)); // R6
endmodule

// File: rtl/inbox_mailbox.sv
module inbox_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              push_valid,
    input  logic [31:0]       push_data,
    input  logic [31:0]       obx_status,
    output logic              irq
);
    dec_t              dec;
    qflags_t           flags;
    logic [WORD_W-1:0] head;
    logic              irq_en;

    mbx_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .dec(dec)
    );

    mbx_queue #(.DEPTH(DEPTH)) u_q (
        .clk(clk), .rst(rst), .pop_req(dec.pop),
        .push_valid(push_valid), .push_data(push_data),
        .head(head), .flags(flags)
    );

    mbx_config u_cfg (
        .clk(clk), .rst(rst), .cfg_wr(dec.cfg_wr),
        .wdata(bus_wdata), .irq_en(irq_en)
    );

    always_comb begin
        case (dec.rsel)
            RSEL_POP:    bus_rdata = flags.empty ? NO_DATA : head;
            RSEL_PEEK:   bus_rdata = head;
            RSEL_STATUS: bus_rdata = status_word(flags);
            RSEL_CONFIG: bus_rdata = config_word(irq_en, !flags.empty);
            RSEL_OBX:    bus_rdata = obx_status;
            default:     bus_rdata = '0;
        endcase
    end

    assign irq = irq_en && !flags.empty;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> irq_en); // R7
    AST_EMPTY_MARKER: assert property (@(posedge clk) disable iff (rst)
        dec.pop && flags.empty |-> bus_rdata == NO_DATA); // R3
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flags.full && flags.empty)); // R5
endmodule

// File: tb/inbox_mailbox_bench.sv
module inbox_mailbox_bench;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam logic [31:0] MARK = 32'hFFFF_FFFF;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        push_valid = 0;
    logic [31:0] push_data = '0;
    logic [31:0] obx_status = 32'h4000_0000;
    logic        irq;

    int total = 0, bad = 0;
    bit live = 0;
    bit done = 0;
    logic [31:0] mq[$];
    bit men = 0;

    always #(PERIOD/2) clk = ~clk;

    inbox_mailbox u_inbox_mailbox (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .push_valid(push_valid), .push_data(push_data),
        .obx_status(obx_status), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(logic [7:0] o);
        logic [31:0] w;
        if (o >= 8'h80 && o <= 8'h8C) return mq.size() ? mq[0] : MARK;
        case (o)
            8'h90: return mq.size() ? mq[0] : MARK;
            8'h98: begin
                w = '0;
                w[31] = (mq.size() == DEPTH);
                w[30] = (mq.size() == 0);
                return w;
            end
            8'h9C: begin
                w = '0;
                w[0] = men;
                w[4] = (mq.size() != 0);
                return w;
            end
            8'hB8: return obx_status;
            default: return 32'h0;
        endcase
    endfunction

    // one bus cycle, optional push in the same cycle
    task automatic cyc(bit sel, bit wr, logic [11:0] a, logic [31:0] wd,
                       bit pv, logic [31:0] pd, string tag);
        logic [7:0] o;
        bit pop;
        bit can_push;
        o = a[7:0];
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        push_valid = pv; push_data = pd;
        #1;
        if (sel && !wr) check(tag, bus_rdata, model_rd(o));
        pop = sel && !wr && o >= 8'h80 && o <= 8'h8C;
        can_push = pv && (mq.size() < DEPTH);
        @(posedge clk);
        if (pop && mq.size() != 0) void'(mq.pop_front());
        if (can_push) mq.push_back(pd);
        if (sel && wr && o == 8'h9C) men = wd[0];
        #1;
        bus_sel = 0; push_valid = 0;
    endtask

    task automatic rd(logic [11:0] a, string tag);
        cyc(1, 0, a, '0, 0, '0, tag);
    endtask
    task automatic wr(logic [11:0] a, logic [31:0] d);
        cyc(1, 1, a, d, 0, '0, "wr");
    endtask
    task automatic push(logic [31:0] d);
        cyc(0, 0, '0, '0, 1, d, "push");
    endtask

    // cycle-by-cycle comparison of the interrupt with the model
    always @(negedge clk) begin
        if (live) check("R7 irq", {31'b0, irq}, {31'b0, men && mq.size() != 0});
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        live = 1;
        // R8 reset state
        rd(12'h098, "R8 status after reset");
        rd(12'h09C, "R8 config after reset");
        rd(12'h090, "R8 head slot marker");
        // R3 empty pop
        rd(12'h080, "R3 empty pop marker");
        rd(12'h098, "R3 still empty");
        // R2 order, pops at all four aliases
        push(32'h1111_0001); push(32'h2222_0002); push(32'h3333_0003); push(32'h4444_0004);
        rd(12'h098, "R5 mid status");
        rd(12'h09C, "R6 pending bit");
        rd(12'h090, "R4 peek");
        rd(12'h090, "R4 peek again");
        rd(12'h080, "R2 pop 80");
        rd(12'h084, "R2 pop 84");
        rd(12'h088, "R2 pop 88");
        rd(12'h08C, "R2 pop 8C");
        rd(12'h090, "R4 peek marker after drain");
        // R6/R7 enable and irq
        wr(12'h09C, 32'hFFFF_FFFE);
        rd(12'h09C, "R6 only bit0 writable (0)");
        wr(12'h09C, 32'hFFFF_FFFF);
        rd(12'h09C, "R6 enable set");
        push(32'hABCD_0000);
        rd(12'h09C, "R6 enable and pending");
        rd(12'h080, "R7 pop to empty");
        // R9 fill and overflow
        for (int i = 0; i < DEPTH + 2; i++) push(32'h5000_0000 + i);
        rd(12'h098, "R9 full status");
        cyc(1, 0, 12'h080, '0, 1, 32'hDEAD_BEEF, "R9 pop with push when full");
        rd(12'h098, "R9 status after drop");
        // R11 push and pop at mid level
        cyc(1, 0, 12'h084, '0, 1, 32'hCAFE_0001, "R11 pop+push mid");
        for (int i = 0; i < DEPTH; i++) rd(12'h080, "R11 drain order");
        rd(12'h098, "R11 empty after drain");
        cyc(1, 0, 12'h080, '0, 1, 32'hCAFE_0002, "R11 pop+push at empty");
        rd(12'h090, "R11 pushed word at head");
        // R10 odd offsets
        wr(12'h094, 32'hFFFF_FFFF);
        rd(12'h094, "R10 sender zero");
        rd(12'h0B8, "R10 outbound status");
        obx_status = 32'h8000_0000;
        rd(12'h0B8, "R10 outbound status full");
        rd(12'h0A0, "R10 unused zero");
        wr(12'h098, 32'hFFFF_FFFF);
        wr(12'h080, 32'h0);
        rd(12'h090, "R10 write to other offsets harmless");
        // R1 aliasing of upper bits
        rd(12'hF98, "R1 status alias");
        rd(12'h380, "R1 pop alias");
        wr(12'h59C, 32'h0);
        rd(12'h09C, "R1 config write alias");
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule